// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Unit

This block sits between a processor's register file and a 32-bit data bus. For a register-indirect load or store it forms the effective address from a base register value and an immediate offset magnitude. A direction bit picks whether the offset is added or subtracted. The block drives the byte strobes and places store data on the byte lanes that match the address. It also checks that the access is aligned.

The memory returns a whole 32-bit word in the cycle after the request. The block keeps the lane position, the access size and the signedness of each load. From these it selects the addressed byte or halfword out of the returned word and extends it to 32 bits, with either zero fill or sign fill.

The permitted offset range depends on the access type. Word accesses, byte stores and unsigned byte loads take a 12-bit magnitude. Signed byte loads and all halfword accesses take only an 8-bit magnitude. A misaligned request raises an error flag and does not reach the bus.

Top module: `ldst_lane_unit`

## Requirements
- R1: While `req_valid` is high, `mem_addr` equals `base + mag` when `up` is 1 and `base - mag` when `up` is 0, modulo 2^32. A zero offset gives `base` unchanged.
- R2: Word loads, word stores, byte stores and unsigned byte loads use all 12 bits of `offs` as the magnitude.
- R3: Signed byte loads, halfword loads and halfword stores use only `offs[7:0]` as the magnitude. For these accesses, `offs[11:8]` has no effect on `mem_addr`.
- R4: Size encoding is `2'b00` byte, `2'b01` halfword, `2'b1x` word. `mem_be` is one-hot at bit `mem_addr[1:0]` for bytes, `4'b0011` or `4'b1100` for halfwords (chosen by `mem_addr[1]`), and `4'b1111` for words.
- R5: A byte store puts `src[7:0]` on the enabled byte lane. A halfword store puts `src[15:0]` on the enabled half. A word store puts `src` unchanged on the bus.
- R6: `align_err` is high exactly when `req_valid` is high and the access is misaligned. A halfword is misaligned when address bit 0 is set; a word is misaligned when address bits 1..0 are not zero. While `align_err` is high, `mem_req` is low.
- R7: `mem_req` equals `req_valid` for aligned accesses, and `mem_we` is high only for an issued store. One cycle after an issued load, `ld_valid` is high and `ld_data` holds the addressed lane of `mem_rdata`. At all other times `ld_valid` is low.
- R8: An unsigned byte or halfword load fills `ld_data` above the loaded field with zeros.
- R9: A signed byte or halfword load copies bit 7 or bit 15 of the loaded field into all upper bits of `ld_data`.
- R10: After reset, with `req_valid` low, both `ld_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| size | input | 2 | 00 byte, 01 halfword, 1x word |
| sext | input | 1 | Sign-extend a narrow load |
| up | input | 1 | 1 = add offset, 0 = subtract |
| base | input | 32 | Base register value |
| offs | input | 12 | Immediate offset magnitude |
| src | input | 32 | Store source register value |
| mem_req | output | 1 | Bus access issued |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-aligned store data |
| mem_rdata | input | 32 | Word returned by memory, one cycle after the request |
| align_err | output | 1 | Misaligned request |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions check the following on every cycle:
- A misaligned request never reaches the bus.
- Byte requests carry exactly one strobe, and word requests carry all four.
- Every issued load is followed by `ld_valid`, and `ld_valid` never appears without an issued load.
- The upper bits of a narrow load result are zero-filled or sign-filled as its signedness requires.

The directed scenarios show what a property cannot easily capture:
- The exact address arithmetic in both directions.
- Which offset width each access type honours.
- The lane the data lands on.
- The value of the selected byte or halfword.

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit #(
  parameter int OFS_LONG  = 12,
  parameter int OFS_SHORT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                is_store,
  input  logic [1:0]          size,
  input  logic                sext,
  input  logic                up,
  input  logic [31:0]         base,
  input  logic [OFS_LONG-1:0] offs,
  input  logic [31:0]         src,
  output logic                mem_req,
  output logic                mem_we,
  output logic [31:0]         mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic                align_err,
  output logic                ld_valid,
  output logic [31:0]         ld_data
);

  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;

  logic        is_b, is_h, is_w, short_ofs, misal;
  logic [31:0] mag;
  logic [1:0]  lane_q, size_q;
  logic        sext_q;
  logic [31:0] shifted;
  logic [15:0] half;

  assign is_b = (size == SZ_B);
  assign is_h = (size == SZ_H);
  assign is_w = size[1];

  assign short_ofs = is_h | (is_b & ~is_store & sext);
  assign mag       = short_ofs ? 32'(offs[OFS_SHORT-1:0]) : 32'(offs);
  assign mem_addr  = up ? base + mag : base - mag;

  assign misal     = (is_h & mem_addr[0]) | (is_w & |mem_addr[1:0]);
  assign align_err = req_valid & misal;
  assign mem_req   = req_valid & ~misal;
  assign mem_we    = mem_req & is_store;

  always_comb begin
    if (is_w)      mem_be = 4'b1111;
    else if (is_h) mem_be = mem_addr[1] ? 4'b1100 : 4'b0011;
    else           mem_be = 4'b0001 << mem_addr[1:0];
  end

  always_comb begin
    if (is_w)      mem_wdata = src;
    else if (is_h) mem_wdata = {2{src[15:0]}};
    else           mem_wdata = {4{src[7:0]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      lane_q   <= 2'b00;
      size_q   <= 2'b00;
      sext_q   <= 1'b0;
    end else begin
      ld_valid <= mem_req & ~is_store;
      if (mem_req & ~is_store) begin
        lane_q <= mem_addr[1:0];
        size_q <= size;
        sext_q <= sext;
      end
    end
  end

  assign shifted = mem_rdata >> {lane_q, 3'b000};
  assign half    = lane_q[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    if (size_q[1])
      ld_data = mem_rdata;
    else if (size_q == SZ_H)
      ld_data = {{16{sext_q & half[15]}}, half};
    else
      ld_data = {{24{sext_q & shifted[7]}}, shifted[7:0]};
  end

endmodule

module ldst_lane_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        is_store,
  input logic [1:0]  size,
  input logic        sext,
  input logic        mem_req,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic        align_err,
  input logic        ld_valid,
  input logic [31:0] ld_data
);

  AST_NO_REQ_ON_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !mem_req); // R6

  AST_BYTE_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && size == 2'b00) |-> $countones(mem_be) == 1); // R4

  AST_WORD_ALL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && size[1]) |-> mem_be == 4'b1111); // R4

  AST_LOAD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> ld_valid); // R7

  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && !is_store)); // R7

  AST_ZERO_FILL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !$past(sext) && $past(size) == 2'b00) |-> ld_data[31:8] == 24'h0); // R8

  AST_SIGN_FILL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(sext) && $past(size) == 2'b01) |-> ld_data[31:16] == {16{ld_data[15]}}); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_req && !align_err); // R10

endmodule

bind ldst_lane_unit ldst_lane_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_store(is_store),
  .size(size), .sext(sext), .mem_req(mem_req), .mem_we(mem_we),
  .mem_be(mem_be), .align_err(align_err), .ld_valid(ld_valid), .ld_data(ld_data)
);

// File: tb/ldst_lane_unit_test.sv
module ldst_lane_unit_test;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, is_store = 0, sext = 0, up = 1;
  logic [1:0]  size = 2'b10;
  logic [31:0] base = 0, src = 0, mem_rdata = 0;
  logic [11:0] offs = 0;
  logic        mem_req, mem_we, align_err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ldst_lane_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_store(is_store),
    .size(size), .sext(sext), .up(up), .base(base), .offs(offs), .src(src),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .align_err(align_err),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic st, logic [1:0] sz, logic sx, logic u,
                       logic [31:0] b, logic [11:0] o, logic [31:0] s);
    @(negedge clk);
    req_valid = 1; is_store = st; size = sz; sext = sx; up = u;
    base = b; offs = o; src = s;
    #1;
  endtask

  task automatic finish_load(string tag, logic [31:0] word, logic [31:0] exp);
    @(negedge clk);
    req_valid = 0; mem_rdata = word;
    #1;
    chk({tag, " ld_valid R7"}, 32'(ld_valid), 1);
    chk({tag, " ld_data"}, ld_data, exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R10 ld_valid after reset", 32'(ld_valid), 0);
    chk("R10 mem_req idle", 32'(mem_req), 0);
  endtask

  task automatic t_word_load;
    issue(0, 2'b10, 0, 1, 32'h1000, 12'h104, 0);
    chk("R1 R2 word load addr", mem_addr, 32'h1104);
    chk("R4 word be", 32'(mem_be), 32'hF);
    chk("R7 mem_we load", 32'(mem_we), 0);
    finish_load("R7 word", 32'hCAFEF00D, 32'hCAFEF00D);
  endtask

  task automatic t_word_store_down;
    issue(1, 2'b10, 0, 0, 32'h2000, 12'h010, 32'h12345678);
    chk("R1 word store down addr", mem_addr, 32'h1FF0);
    chk("R5 word wdata", mem_wdata, 32'h12345678);
    chk("R7 mem_we store", 32'(mem_we), 1);
    @(negedge clk); req_valid = 0; #1;
    chk("R7 no ld_valid after store", 32'(ld_valid), 0);
  endtask

  task automatic t_zero_offset;
    issue(0, 2'b10, 0, 0, 32'hABCD0010, 0, 0);
    chk("R1 zero offset", mem_addr, 32'hABCD0010);
    finish_load("R1 zero", 32'h5, 32'h5);
  endtask

  task automatic t_byte_store;
    issue(1, 2'b00, 0, 1, 32'h10002, 12'hFFF, 32'hAABBCC5A);
    chk("R2 byte store long offset", mem_addr, 32'h11001);
    chk("R4 byte be lane1", 32'(mem_be), 32'h2);
    chk("R5 byte lane1 data", 32'(mem_wdata[15:8]), 32'h5A);
  endtask

  task automatic t_ubyte_load;
    issue(0, 2'b00, 0, 1, 0, 12'h203, 0);
    chk("R2 unsigned byte long offset", mem_addr, 32'h203);
    chk("R4 byte be lane3", 32'(mem_be), 32'h8);
    finish_load("R8 unsigned byte", 32'h85112233, 32'h00000085);
  endtask

  task automatic t_sbyte_load;
    issue(0, 2'b00, 1, 1, 32'h100, 12'h303, 0);
    chk("R3 signed byte short offset", mem_addr, 32'h103);
    finish_load("R9 signed byte", 32'h85112233, 32'hFFFFFF85);
  endtask

  task automatic t_half_loads;
    issue(0, 2'b01, 1, 1, 32'h200, 12'hF02, 0);
    chk("R3 half short offset", mem_addr, 32'h202);
    chk("R4 half be upper", 32'(mem_be), 32'hC);
    finish_load("R9 signed half", 32'h80011234, 32'hFFFF8001);
    issue(0, 2'b01, 0, 1, 32'h200, 12'hA00, 0);
    chk("R3 half ignores high offs", mem_addr, 32'h200);
    chk("R4 half be lower", 32'(mem_be), 32'h3);
    finish_load("R8 unsigned half", 32'h1234F00F, 32'h0000F00F);
  endtask

  task automatic t_half_store;
    issue(1, 2'b01, 0, 0, 32'h400, 12'h902, 32'hDEADBEEF);
    chk("R3 half store down", mem_addr, 32'h3FE);
    chk("R4 half store be", 32'(mem_be), 32'hC);
    chk("R5 half upper data", 32'(mem_wdata[31:16]), 32'hBEEF);
  endtask

  task automatic t_misaligned;
    issue(0, 2'b01, 0, 1, 32'h201, 0, 0);
    chk("R6 half misaligned err", 32'(align_err), 1);
    chk("R6 half misaligned no req", 32'(mem_req), 0);
    @(negedge clk); req_valid = 0; #1;
    chk("R7 no ld_valid after misaligned", 32'(ld_valid), 0);
    issue(1, 2'b10, 0, 1, 32'h100, 12'h2, 0);
    chk("R6 word misaligned err", 32'(align_err), 1);
    chk("R6 word misaligned no we", 32'(mem_we), 0);
    issue(0, 2'b00, 0, 1, 32'h101, 0, 0);
    chk("R6 byte never misaligned", 32'(align_err), 0);
    @(negedge clk); req_valid = 0; #1;
    chk("R6 idle no err", 32'(align_err), 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_word_load();
    t_word_store_down();
    t_zero_offset();
    t_byte_store();
    t_ubyte_load();
    t_sbyte_load();
    t_half_loads();
    t_half_store();
    t_misaligned();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule